// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that gives a bus master byte-wide access to a register file held inside the block. The system clock oversamples SCL and SDA. The block detects START, repeated START and STOP from the sampled lines, then decodes a fixed 7-bit device address and the direction bit that follows it.

In a write transfer, the first byte after the address sets an internal pointer. Each byte after that is stored at the pointer, and the pointer then steps to the next location. In a read transfer, the block returns bytes starting at the pointer and steps the pointer after each byte. A repeated START leaves the pointer unchanged, so a master can set the pointer in a write transfer and read from that location in the next transfer.

SDA is driven only through an open-drain enable. The block can pull the line low or release it, and never drives it high.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset, `sda_oe` is 0, the pointer is 0, and all 256 register bytes read back as 0x00.
- R2: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. After a STOP the block releases SDA and stays idle until the next START.
- R3: The block accepts only the address 1101000, sent MSB first in bits 7..1 of the first byte after a START. Bit 0 of that byte is the direction: 0 means write and 1 means read. On a match the block pulls SDA low in the ninth clock. On a mismatch SDA stays released for the ninth clock and for all later clocks, and no register changes until the next START.
- R4: In a write transfer, the first byte after the address loads the pointer. Each later byte is stored at the pointer, and the pointer then increments.
- R5: In a read transfer, the block sends the byte at the pointer MSB first, then increments the pointer. While the master acknowledges, the block goes on with the next location.
- R6: A repeated START keeps the pointer, so a read that follows a pointer write starts at the written location.
- R7: When the master answers a byte with a not-acknowledge (SDA high), the block sends nothing more until a START or STOP. The next read starts at the location after the byte that was not acknowledged.
- R8: The pointer wraps from 255 to 0, in both writes and reads.
- R9: `sda_oe` changes only while the synchronized SCL is low, except that a START or STOP releases it. The block leaves SDA released during every bit the master drives.
- R10: The block acknowledges every byte it receives, that is, the pointer byte and each data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Internal state reaches the ports only through `sda_oe`. The bench therefore compares `sda_oe` with a reference model on every system clock while SCL is high, for every bit including acknowledge slots.

Each internal fault shows up on the bus:
- A wrong bit or byte counter makes the acknowledge land in the wrong clock, or makes the block drive SDA during a bit the master owns. This shows within the same byte.
- A pointer fault, or a pointer lost across a repeated START, shows as wrong read data in the first byte read after it.
- A missed address mismatch shows as an acknowledge in the ninth clock, and later as changed contents when the register is read back.

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter logic [6:0] DEV_ADDR = 7'b1101000,
  parameter int         REG_AW   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int REG_N = 1 << REG_AW;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {P_ADDR, P_PTR, P_DATA} ph_t;

  logic [1:0]        scl_sync, sda_sync;
  logic              scl_d, sda_d;
  st_t               state;
  ph_t               phase;
  logic              rd, mack_nak;
  logic [7:0]        shreg;
  logic [3:0]        bitcnt;
  logic [REG_AW-1:0] ptr;
  logic [7:0]        mem [REG_N];

  wire scl_s    = scl_sync[1];
  wire sda_s    = sda_sync[1];
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire [REG_AW-1:0] ptr_nx = ptr + REG_AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      phase    <= P_ADDR;
      rd       <= 1'b0;
      mack_nak <= 1'b0;
      shreg    <= '0;
      bitcnt   <= '0;
      ptr      <= '0;
      sda_oe   <= 1'b0;
      for (int i = 0; i < REG_N; i++) mem[i] <= '0;
    end else if (stop_c) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else if (start_c) begin
      state  <= S_RX;
      phase  <= P_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        S_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt <= '0;
            case (phase)
              P_ADDR: begin
                if (shreg[7:1] == DEV_ADDR) begin
                  rd     <= shreg[0];
                  phase  <= P_PTR;
                  sda_oe <= 1'b1;
                  state  <= S_ACK;
                end else begin
                  state <= S_IDLE;
                end
              end
              P_PTR: begin
                ptr    <= shreg[REG_AW-1:0];
                phase  <= P_DATA;
                sda_oe <= 1'b1;
                state  <= S_ACK;
              end
              default: begin
                mem[ptr] <= shreg;
                ptr      <= ptr_nx;
                sda_oe   <= 1'b1;
                state    <= S_ACK;
              end
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            if (rd) begin
              shreg  <= mem[ptr];
              sda_oe <= ~mem[ptr][7];
              bitcnt <= '0;
              state  <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_oe <= 1'b0;
              ptr    <= ptr_nx;
              state  <= S_MACK;
            end else begin
              sda_oe <= ~shreg[6];
              shreg  <= {shreg[6:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            mack_nak <= sda_s;
          end else if (scl_fall) begin
            if (mack_nak) begin
              state <= S_IDLE;
            end else begin
              shreg  <= mem[ptr];
              sda_oe <= ~mem[ptr][7];
              bitcnt <= '0;
              state  <= S_TX;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R9
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!$past(scl_s) || $past(start_c) || $past(stop_c)));

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (!sda_oe && state == S_IDLE));

  // R2
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (!sda_oe && bitcnt == 4'd0));

  // R4
  ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> $past(scl_fall));

  // R10
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd8);
endmodule

// File: tb/i2c_regfile_target_tb.sv
`timescale 1ns/100ps
module i2c_regfile_target_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  bit   chk_en = 1'b0;
  logic exp_oe = 1'b0;
  string chk_req = "";

  logic [7:0] model_mem [256];
  int         model_ptr = 0;

  always #2.5 clk = ~clk;

  i2c_regfile_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  always @(negedge clk) begin
    if (chk_en) begin
      checks++;
      if (sda_oe !== exp_oe) begin
        errors++;
        $display("FAIL %s: sda_oe=%b expected %b at %0t", chk_req, sda_oe, exp_oe, $time);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clk_bit(input logic mbit, input logic eoe, input string req, output logic seen);
    wait_clk(10); sda_m = mbit;
    wait_clk(10); scl_m = 1'b1; exp_oe = eoe; chk_req = req; chk_en = 1'b1;
    wait_clk(10); seen = sda_line;
    wait_clk(10); chk_en = 1'b0; scl_m = 1'b0;
  endtask

  task automatic i2c_start();
    wait_clk(10); sda_m = 1'b1;
    wait_clk(10); scl_m = 1'b1;
    wait_clk(10); sda_m = 1'b0;
    wait_clk(10); scl_m = 1'b0;
  endtask

  task automatic i2c_stop(input string req);
    wait_clk(10); sda_m = 1'b0;
    wait_clk(10); scl_m = 1'b1;
    wait_clk(10); sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wait_clk(1);
      checks++;
      if (sda_oe !== 1'b0) begin
        errors++;
        $display("FAIL %s: sda_oe=%b expected 0 after stop", req, sda_oe);
      end
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic ack_exp, input string req);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0, "R9", s);
    clk_bit(1'b1, ack_exp, req, s);
  endtask

  task automatic recv_byte(input logic mack, input string req);
    logic [7:0] expb, got;
    logic s;
    expb = model_mem[model_ptr];
    model_ptr = (model_ptr + 1) % 256;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, ~expb[i], req, s);
      got[i] = s;
    end
    clk_bit(mack ? 1'b0 : 1'b1, 1'b0, "R9", s);
    checks++;
    if (got !== expb) begin
      errors++;
      $display("FAIL %s: read byte %h expected %h", req, got, expb);
    end
  endtask

  task automatic write_txn(input logic [7:0] p, input logic [7:0] data[$]);
    i2c_start();
    send_byte(8'hD0, 1'b1, "R3");
    send_byte(p, 1'b1, "R10");
    model_ptr = p;
    foreach (data[k]) begin
      send_byte(data[k], 1'b1, "R4");
      model_mem[model_ptr] = data[k];
      model_ptr = (model_ptr + 1) % 256;
    end
    i2c_stop("R2");
  endtask

  task automatic ptr_then_read(input logic [7:0] p, input int n, input string req);
    i2c_start();
    send_byte(8'hD0, 1'b1, "R3");
    send_byte(p, 1'b1, "R10");
    model_ptr = p;
    i2c_start();
    send_byte(8'hD1, 1'b1, "R6");
    for (int k = 0; k < n; k++) recv_byte(k != n - 1, req);
  endtask

  initial begin
    logic s;
    for (int i = 0; i < 256; i++) model_mem[i] = 8'h00;
    wait_clk(10);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      wait_clk(1);
      checks++;
      if (sda_oe !== 1'b0) begin
        errors++;
        $display("FAIL R1: sda_oe=%b expected 0 after reset", sda_oe);
      end
    end
    // R1: current-pointer read right after reset returns location 0
    i2c_start();
    send_byte(8'hD1, 1'b1, "R3");
    model_ptr = 0;
    recv_byte(1'b0, "R1");
    i2c_stop("R2");

    // R4 / R10: write three bytes
    write_txn(8'h20, '{8'h5A, 8'hC3, 8'h0F});

    // R6 / R5: pointer write, repeated start, read with auto-increment; R7 nack
    ptr_then_read(8'h20, 3, "R5");
    clk_bit(1'b1, 1'b0, "R7", s);
    clk_bit(1'b1, 1'b0, "R7", s);
    i2c_stop("R7");

    // R7: next current-pointer read continues after the nacked byte
    i2c_start();
    send_byte(8'hD1, 1'b1, "R3");
    recv_byte(1'b0, "R7");
    i2c_stop("R2");

    // R8: wrap on write and on read
    write_txn(8'hFE, '{8'h11, 8'h22, 8'h33});
    ptr_then_read(8'hFF, 3, "R8");
    i2c_stop("R2");

    // R3: wrong address, write attempt ignored
    i2c_start();
    send_byte(8'hA0, 1'b0, "R3");
    send_byte(8'h21, 1'b0, "R3");
    send_byte(8'hEE, 1'b0, "R3");
    i2c_stop("R2");
    // R3: near-miss address in read direction, no drive at all
    i2c_start();
    send_byte(8'hD3, 1'b0, "R3");
    for (int i = 0; i < 9; i++) clk_bit(1'b1, 1'b0, "R3", s);
    i2c_stop("R2");
    ptr_then_read(8'h20, 2, "R3");
    i2c_stop("R2");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule